// File: doc/BRIEF.md
# Periodic Battery Test Scheduler

This block decides when a backup battery is put under load for a health check, and it keeps a flag that says whether the battery passed its most recent check. As soon as main power is reported valid, a first load test begins. Once that test is over, further tests follow at a long fixed spacing. While a test runs, a strobe output is high so that an external load can be switched across the battery. In the last cycle of the test, the block samples a comparator that reports "battery above the OK threshold", and it stores that result as the battery-OK flag.

When the system runs from the battery (backup mode), testing is suppressed and the battery-OK flag is forced low. When backup mode ends, the sequence starts over with a fresh power-up test, and the flag stays low until that test passes. Every duration is a parameter counted in clock ticks, so a simulation can shrink a 24-hour spacing down to a handful of cycles. The defaults assume a 1 kHz tick.

Top module: `batt_test_sched`

## Requirements
- R1: After reset, `test_active` and `batt_ok` are 0. Both stay 0 for as long as `main_ok` is 0.
- R2: When `main_ok` is sampled 1 with `backup_mode` 0 while no sequence is running, `test_active` rises in the next cycle and stays 1 for exactly `TEST_TICKS` cycles.
- R3: After each complete test, `test_active` stays 0 for exactly `GAP_TICKS` cycles and then a new test begins. The spacing counter does not advance during a test, so one period is `TEST_TICKS + GAP_TICKS` cycles.
- R4: At the end of each test, `batt_ok` takes the value that `batt_above` had in the last test cycle. The new value is visible in the cycle after that last test cycle. `batt_above` has no effect in any other cycle.
- R5: Between tests, `batt_ok` holds its value, whatever `batt_above` does.
- R6: When `backup_mode` is sampled 1, `test_active` and `batt_ok` are both 0 from the next cycle on, for as long as `backup_mode` stays 1. A test that is running is abandoned.
- R7: When `backup_mode` returns to 0 while `main_ok` is 1, a new power-up test starts in the next cycle. `batt_ok` stays 0 until that test ends with `batt_above` 1.
- R8: When `main_ok` is sampled 0 while `backup_mode` is 0, any test is abandoned, `test_active` is 0 from the next cycle, and `batt_ok` holds its value. The next time `main_ok` is sampled 1, a power-up test starts as in R2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock (one tick) |
| rst | input | 1 | Synchronous active-high reset |
| main_ok | input | 1 | Main power is valid |
| backup_mode | input | 1 | System is running from the backup battery |
| batt_above | input | 1 | Comparator result: battery is above the OK threshold |
| test_active | output | 1 | High while a load test is running; switches the external load |
| batt_ok | output | 1 | Result of the latest completed test; low in backup mode |

## Verification
Four checks are evaluated on every cycle:
- a test never lasts longer than `TEST_TICKS` cycles;
- a rising `main_ok` starts a test in the next cycle;
- backup mode silences both outputs one cycle later;
- `batt_ok` only changes in the cycle right after a test cycle or a backup cycle.

Some behaviour can only be shown by the bench's scenarios, which compare against a cycle-by-cycle model:
- the exact test length and the exact spacing between tests;
- that the sampled comparator value is the one from the last test cycle;
- that the flag holds while the comparator toggles between tests;
- the restart after backup mode or a power loss.

// File: rtl/bt_pkg.sv
package bt_pkg;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_LOAD = 2'd1,
        PH_REST = 2'd2
    } bt_phase_e;

    typedef struct packed {
        logic clear;
        logic advance;
        logic test_end;
        logic force_low;
    } bt_ctrl_t;

    function automatic int span_width(input int a, input int b);
        int m;
        m = (a > b) ? a : b;
        return (m <= 2) ? 1 : $clog2(m);
    endfunction

endpackage

// File: rtl/bt_span_counter.sv
module bt_span_counter #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clear,
    input  logic         advance,
    input  logic [W-1:0] last_val,
    output logic         done
);
    logic [W-1:0] count;

    assign done = (count == last_val);

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            count <= '0;
        end else if (advance) begin
            if (done) count <= '0;
            else      count <= count + 1'b1;
        end
    end
endmodule

// File: rtl/bt_sequencer.sv
module bt_sequencer
    import bt_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      main_ok,
    input  logic      backup_mode,
    input  logic      span_done,
    output bt_phase_e phase,
    output bt_ctrl_t  ctrl
);
    bt_phase_e phase_nx;
    logic      halt;

    assign halt = backup_mode || !main_ok;

    always_comb begin
        ctrl.force_low = backup_mode;
        ctrl.clear     = halt || (phase == PH_IDLE);
        ctrl.advance   = (phase != PH_IDLE);
        ctrl.test_end  = !halt && (phase == PH_LOAD) && span_done;
    end

    always_comb begin
        phase_nx = phase;
        if (halt) begin
            phase_nx = PH_IDLE;
        end else begin
            unique case (phase)
                PH_IDLE: phase_nx = PH_LOAD;
                PH_LOAD: if (span_done) phase_nx = PH_REST;
                PH_REST: if (span_done) phase_nx = PH_LOAD;
                default: phase_nx = PH_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) phase <= PH_IDLE;
        else     phase <= phase_nx;
    end
endmodule

// File: rtl/bt_status.sv
module bt_status
    import bt_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  bt_ctrl_t ctrl,
    input  logic     batt_above,
    output logic     batt_ok
);
    always_ff @(posedge clk) begin
        if (rst || ctrl.force_low) begin
            batt_ok <= 1'b0;
        end else if (ctrl.test_end) begin
            batt_ok <= batt_above;
        end
    end
endmodule

// File: rtl/batt_test_sched.sv
module batt_test_sched
    import bt_pkg::*;
#(
    parameter int TEST_TICKS = 1235,
    parameter int GAP_TICKS  = 86_400_000
) (
    input  logic clk,
    input  logic rst,
    input  logic main_ok,
    input  logic backup_mode,
    input  logic batt_above,
    output logic test_active,
    output logic batt_ok
);
    localparam int CW = span_width(TEST_TICKS, GAP_TICKS);
    localparam logic [CW-1:0] LOAD_LAST = CW'(TEST_TICKS - 1);
    localparam logic [CW-1:0] REST_LAST = CW'(GAP_TICKS - 1);

    bt_phase_e    phase;
    bt_ctrl_t     ctrl;
    logic         span_done;
    logic [CW-1:0] span_last;

    assign span_last   = (phase == PH_LOAD) ? LOAD_LAST : REST_LAST;
    assign test_active = (phase == PH_LOAD);

    bt_sequencer u_seq (
        .clk        (clk),
        .rst        (rst),
        .main_ok    (main_ok),
        .backup_mode(backup_mode),
        .span_done  (span_done),
        .phase      (phase),
        .ctrl       (ctrl)
    );

    bt_span_counter #(.W(CW)) u_span (
        .clk     (clk),
        .rst     (rst),
        .clear   (ctrl.clear),
        .advance (ctrl.advance),
        .last_val(span_last),
        .done    (span_done)
    );

    bt_status u_stat (
        .clk       (clk),
        .rst       (rst),
        .ctrl      (ctrl),
        .batt_above(batt_above),
        .batt_ok   (batt_ok)
    );
endmodule

// File: rtl/batt_test_sched_chk.sv
module batt_test_sched_chk #(
    parameter int TEST_TICKS = 1235
) (
    input logic clk,
    input logic rst,
    input logic main_ok,
    input logic backup_mode,
    input logic test_active,
    input logic batt_ok
);
    int run_len;

    always_ff @(posedge clk) begin
        if (rst)              run_len <= 0;
        else if (test_active) run_len <= run_len + 1;
        else                  run_len <= 0;
    end

    // R2: a test never runs longer than TEST_TICKS cycles
    a_r2_test_bounded: assert property (@(posedge clk) disable iff (rst)
        test_active |-> (run_len < TEST_TICKS));

    // R2: power arriving from idle starts a test in the next cycle
    a_r2_start_on_power: assert property (@(posedge clk) disable iff (rst)
        (main_ok && !backup_mode && !$past(main_ok)) |=> test_active);

    // R6: backup mode silences both outputs one cycle later
    a_r6_backup_quiet: assert property (@(posedge clk) disable iff (rst)
        backup_mode |=> (!test_active && !batt_ok));

    // R5: the flag moves only right after a test cycle or a backup cycle
    a_r5_flag_held: assert property (@(posedge clk) disable iff (rst)
        !$stable(batt_ok) |-> ($past(test_active) || $past(backup_mode)));
endmodule

bind batt_test_sched batt_test_sched_chk #(.TEST_TICKS(TEST_TICKS)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .main_ok    (main_ok),
    .backup_mode(backup_mode),
    .test_active(test_active),
    .batt_ok    (batt_ok)
);

// File: tb/batt_test_sched_bench.sv
module batt_test_sched_bench;
    localparam int TT = 5;
    localparam int GT = 12;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic main_ok = 1'b0;
    logic backup_mode = 1'b0;
    logic batt_above = 1'b0;
    logic test_active;
    logic batt_ok;

    int    n_checks = 0;
    int    n_err = 0;
    string cur_req = "R1";

    // reference model state
    int m_phase = 0;   // 0 idle, 1 testing, 2 resting
    int m_elapsed = 0;
    bit m_ok = 1'b0;

    // run-length monitor
    bit mon_en = 1'b0;
    int act_run = 0;
    int gap_run = 0;
    bit gap_valid = 1'b0;

    always #4 clk = ~clk;

    batt_test_sched #(.TEST_TICKS(TT), .GAP_TICKS(GT)) u_batt_test_sched (
        .clk(clk), .rst(rst), .main_ok(main_ok), .backup_mode(backup_mode),
        .batt_above(batt_above), .test_active(test_active), .batt_ok(batt_ok)
    );

    task automatic check_bit(input logic act, input logic exp, input string what);
        n_checks++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s %s actual=%0b expected=%0b at %0t", cur_req, what, act, exp, $time);
        end
    endtask

    task automatic check_int(input int act, input int exp, input string req, input string what);
        n_checks++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
        end
    endtask

    // model advances on the clock edge from inputs set well after the previous edge
    always @(posedge clk) begin
        if (rst || backup_mode) begin
            m_phase = 0; m_elapsed = 0;
            m_ok = 1'b0;
        end else if (!main_ok) begin
            m_phase = 0; m_elapsed = 0;
        end else if (m_phase == 0) begin
            m_phase = 1; m_elapsed = 0;
        end else begin
            m_elapsed++;
            if (m_phase == 1 && m_elapsed == TT) begin
                m_ok = batt_above;
                m_phase = 2; m_elapsed = 0;
            end else if (m_phase == 2 && m_elapsed == GT) begin
                m_phase = 1; m_elapsed = 0;
            end
        end
    end

    // compare on every clock, away from the active edge
    always @(negedge clk) begin
        check_bit(test_active, (m_phase == 1), "test_active");
        check_bit(batt_ok, m_ok, "batt_ok");
        if (!mon_en) begin
            act_run = 0; gap_run = 0; gap_valid = 1'b0;
        end else if (test_active) begin
            if (act_run == 0 && gap_valid)
                check_int(gap_run, GT, "R3", "rest length");
            act_run++;
            gap_run = 0;
        end else begin
            if (act_run > 0) begin
                check_int(act_run, TT, "R2", "test length");
                gap_valid = 1'b1;
                gap_run = 0;
            end
            act_run = 0;
            gap_run++;
        end
    end

    task automatic step(input int n);
        for (int i = 0; i < n; i++) @(posedge clk);
        #1;
    endtask

    task automatic wait_test_active();
        int guard = 0;
        while (!test_active && guard < 100) begin
            step(1);
            guard++;
        end
    endtask

    initial begin : watchdog
        repeat (5000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", n_err, n_checks);
        $finish;
    end

    initial begin : stim
        logic [7:0] lfsr;
        lfsr = 8'hA5;
        step(3);
        rst = 1'b0;
        cur_req = "R1";
        step(6);
        check_bit(test_active, 1'b0, "idle strobe R1");
        check_bit(batt_ok, 1'b0, "idle flag R1");

        cur_req = "R2";
        mon_en = 1'b1;
        main_ok = 1'b1;
        batt_above = 1'b1;
        step(1);
        check_bit(test_active, 1'b1, "power-up start R2");
        step(20);
        cur_req = "R3";
        step(25);

        cur_req = "R4";
        for (int i = 0; i < 70; i++) begin
            batt_above = lfsr[0];
            lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
            step(1);
        end

        cur_req = "R5";
        for (int i = 0; i < 40; i++) begin
            batt_above = ~batt_above;
            step(1);
        end

        mon_en = 1'b0;
        cur_req = "R6";
        batt_above = 1'b1;
        wait_test_active();
        step(2);
        backup_mode = 1'b1;
        step(1);
        check_bit(test_active, 1'b0, "backup strobe R6");
        check_bit(batt_ok, 1'b0, "backup flag R6");
        step(10);

        cur_req = "R7";
        batt_above = 1'b0;
        backup_mode = 1'b0;
        step(1);
        check_bit(test_active, 1'b1, "restart after backup R7");
        step(TT + 2);
        check_bit(batt_ok, 1'b0, "failed retest R7");
        batt_above = 1'b1;
        step(GT + TT + 2);
        check_bit(batt_ok, 1'b1, "passed retest R7");

        cur_req = "R8";
        wait_test_active();
        step(2);
        batt_above = 1'b0;
        main_ok = 1'b0;
        step(1);
        check_bit(test_active, 1'b0, "abort on power loss R8");
        check_bit(batt_ok, 1'b1, "flag held on power loss R8");
        step(6);
        main_ok = 1'b1;
        step(1);
        check_bit(test_active, 1'b1, "power-up test again R8");
        step(25);

        $display("Result: errors=%0d of %0d checks", n_err, n_checks);
        $finish;
    end
endmodule